// File: doc/BRIEF.md
# Systematic Reed-Solomon Stream Encoder

This block is a streaming systematic Reed-Solomon encoder over GF(2^8). By default it produces a 204-symbol codeword from 188 information symbols. It takes one 8-bit information symbol per clock and passes the symbol to the output unchanged and in order. In the same cycle the symbol enters a remainder circuit: a chain of 16 symbol registers linked by fixed-constant field multipliers and XOR adders.

When the final information symbol of a block has been taken, the output selector moves to the remainder registers. It shifts the 16 check symbols out on 16 consecutive clocks, highest-degree term first. During that window the input handshake is closed. The field polynomial (default 285, x^8+x^4+x^3+x^2+1) and the first root exponent of the generator (default 0) are elaboration-time parameters. The generator coefficients are derived from them when the design is elaborated.

A source starts each block with a start flag on its first symbol. It may pause between symbols at will. It can begin the next block in the first cycle the handshake reopens.

Top module: `rs_stream_encoder`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, out_valid, out_parity and out_last are 0 and in_ready is 1.
- R2: A symbol taken at a clock edge (in_valid and in_ready high, plus in_sop or a block already open) appears on out_data at that same edge, with out_valid=1 and out_parity=0 and its value unchanged.
- R3: When no block is open, a symbol offered without in_sop is not taken. No output symbol results, and it does not count towards a block.
- R4: The 16 check symbols equal the remainder of m(x)*x^16 divided by g(x) = prod over i=0..15 of (x + a^(ROOT0+i)), where a=2 in the field of polynomial 285 and the first information symbol is the highest-degree coefficient. The 204 output symbols therefore have all 16 syndromes at those roots equal to zero.
- R5: The clock after the 188th information symbol is shown, the 16 check symbols follow on 16 consecutive cycles with out_valid=1 and out_parity=1, highest degree first.
- R6: in_ready is 0 from the edge that takes the 188th symbol until the edge that shows the 16th check symbol. Symbols offered in that window are ignored. in_ready is 1 in the cycle that shows the 16th check symbol.
- R7: out_last is 1 only together with the 16th check symbol of a codeword.
- R8: Cycles with in_valid low inside a block produce no output symbol and leave the block position and remainder unchanged.
- R9: A symbol with in_sop taken while a block is partly filled abandons that block. The remainder restarts from zero and this symbol becomes information symbol 1.
- R10: Codewords can run back to back: a new block's first symbol is taken in the first cycle in_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information symbol offered |
| in_sop | input | 1 | Offered symbol is the first of a block |
| in_data | input | 8 | Information symbol |
| in_ready | output | 1 | Encoder can take a symbol this cycle |
| out_valid | output | 1 | out_data holds a codeword symbol |
| out_data | output | 8 | Codeword symbol |
| out_parity | output | 1 | out_data is a check symbol |
| out_last | output | 1 | out_data is the final symbol of the codeword |

## Verification
Two events can share one cycle. In the first, the last check symbol is shown and the handshake reopens, and the source offers the first symbol of the next block in that same cycle. In the second, a start flag arrives while a block is half filled, so the clear of the remainder and the first feedback step happen on one edge. The bench provokes both: back-to-back blocks with no idle cycle between them, and a 50-symbol fragment followed at once by a full block. A queue-based division model predicts every output cycle. A syndrome evaluation over each emitted codeword confirms that the restart left no trace of the abandoned fragment.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    typedef enum logic {
        PH_INFO  = 1'b0,
        PH_CHECK = 1'b1
    } enc_phase_e;

    typedef struct packed {
        logic take;
        logic restart;
        logic final_info;
        logic shift;
        logic final_chk;
    } enc_ctrl_t;

    // Field product of a and b, bit-serial reduction by poly (w-bit symbols).
    function automatic int gf_mul(input int a, input int b, input int poly, input int w);
        int acc;
        int aa;
        acc = 0;
        aa  = a;
        for (int i = 0; i < w; i++) begin
            if (((b >> i) & 1) != 0) acc = acc ^ aa;
            aa = aa << 1;
            if (((aa >> w) & 1) != 0) aa = aa ^ poly;
        end
        return acc;
    endfunction

    // Primitive element (value 2) raised to e.
    function automatic int gf_alpha_pow(input int e, input int poly, input int w);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = gf_mul(r, 2, poly, w);
        return r;
    endfunction

    // Coefficient of x^idx in prod_{i<nroots} (x + alpha^(root0+i)).
    function automatic int gen_coef(input int idx, input int nroots, input int root0,
                                    input int poly, input int w);
        int g [0:255];
        int rt;
        for (int k = 0; k < 256; k++) g[k] = 0;
        g[0] = 1;
        for (int i = 0; i < nroots; i++) begin
            rt = gf_alpha_pow(root0 + i, poly, w);
            for (int k = i + 1; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], rt, poly, w);
            g[0] = gf_mul(g[0], rt, poly, w);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs_gf_const_mul.sv
module rs_gf_const_mul #(
    parameter int W     = 8,
    parameter int POLY  = 285,
    parameter int CONST = 1
) (
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] prod_o
);
    logic [W-1:0] part [W];

    for (genvar b = 0; b < W; b++) begin : g_col
        localparam logic [W-1:0] COL = W'(rs_enc_pkg::gf_mul(CONST, 1 << b, POLY, W));
        assign part[b] = sym_i[b] ? COL : '0;
    end

    always_comb begin
        prod_o = '0;
        for (int b = 0; b < W; b++) prod_o = prod_o ^ part[b];
    end
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
    parameter int K = 188,
    parameter int P = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_sop,
    output logic                  in_ready,
    output rs_enc_pkg::enc_ctrl_t ctrl
);
    import rs_enc_pkg::*;

    localparam int CW = $clog2(K + 1);
    localparam int PW = (P > 1) ? $clog2(P) : 1;

    enc_phase_e     phase_q;
    logic [CW-1:0]  info_cnt_q;
    logic [PW-1:0]  chk_cnt_q;
    logic [CW-1:0]  info_cnt_nx;

    assign in_ready        = (phase_q == PH_INFO);
    assign ctrl.take       = in_valid && in_ready && (in_sop || (info_cnt_q != '0));
    assign ctrl.restart    = ctrl.take && in_sop;
    assign info_cnt_nx     = ctrl.restart ? CW'(1) : CW'(info_cnt_q + 1'b1);
    assign ctrl.final_info = ctrl.take && (info_cnt_nx == CW'(K));
    assign ctrl.shift      = (phase_q == PH_CHECK);
    assign ctrl.final_chk  = ctrl.shift && (chk_cnt_q == PW'(P - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_INFO;
            info_cnt_q <= '0;
            chk_cnt_q  <= '0;
        end else begin
            if (ctrl.final_info) begin
                phase_q    <= PH_CHECK;
                info_cnt_q <= '0;
                chk_cnt_q  <= '0;
            end else if (ctrl.take) begin
                info_cnt_q <= info_cnt_nx;
            end
            if (ctrl.shift) begin
                chk_cnt_q <= PW'(chk_cnt_q + 1'b1);
                if (ctrl.final_chk) phase_q <= PH_INFO;
            end
        end
    end
endmodule

// File: rtl/rs_remainder_lfsr.sv
module rs_remainder_lfsr #(
    parameter int W     = 8,
    parameter int P     = 16,
    parameter int POLY  = 285,
    parameter int ROOT0 = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic         restart,
    input  logic         shift,
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] top_o
);
    logic [W-1:0] rem_q [P];
    logic [W-1:0] prod  [P];
    logic [W-1:0] fb;

    // Feedback is held at zero while check symbols drain, turning the chain into a shifter.
    assign fb    = shift ? '0 : (sym_i ^ (restart ? '0 : rem_q[P-1]));
    assign top_o = rem_q[P-1];

    for (genvar i = 0; i < P; i++) begin : g_stage
        localparam int COEF = rs_enc_pkg::gen_coef(i, P, ROOT0, POLY, W);
        logic [W-1:0] base;

        rs_gf_const_mul #(.W(W), .POLY(POLY), .CONST(COEF)) mul_i (
            .sym_i  (fb),
            .prod_o (prod[i])
        );

        if (i == 0) begin : g_first
            assign base = '0;
        end else begin : g_rest
            assign base = restart ? '0 : rem_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rem_q[i] <= '0;
            end else if (take || shift) begin
                rem_q[i] <= base ^ prod[i];
            end
        end
    end
endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder #(
    parameter int SYM_W    = 8,
    parameter int CODE_LEN = 204,
    parameter int CHK_SYMS = 16,
    parameter int FIELD_PP = 285,
    parameter int ROOT0    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_parity,
    output logic             out_last
);
    import rs_enc_pkg::*;

    localparam int INFO_LEN = CODE_LEN - CHK_SYMS;

    enc_ctrl_t        ctrl;
    logic [SYM_W-1:0] chk_sym;

    rs_enc_ctrl #(.K(INFO_LEN), .P(CHK_SYMS)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_ready (in_ready),
        .ctrl     (ctrl)
    );

    rs_remainder_lfsr #(.W(SYM_W), .P(CHK_SYMS), .POLY(FIELD_PP), .ROOT0(ROOT0)) rem_i (
        .clk     (clk),
        .rst     (rst),
        .take    (ctrl.take),
        .restart (ctrl.restart),
        .shift   (ctrl.shift),
        .sym_i   (in_data),
        .top_o   (chk_sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_parity <= 1'b0;
            out_last   <= 1'b0;
        end else begin
            out_valid  <= ctrl.take || ctrl.shift;
            out_parity <= ctrl.shift;
            out_last   <= ctrl.final_chk;
            if (ctrl.shift)     out_data <= chk_sym;
            else if (ctrl.take) out_data <= in_data;
        end
    end
endmodule

// File: rtl/rs_stream_encoder_sva.sv
module rs_stream_encoder_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_sop,
    input logic [W-1:0] in_data,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         out_parity,
    input logic         out_last
);
    AST_SOP_PASSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_sop) |=> (out_valid && !out_parity && out_data == $past(in_data))); // R2

    AST_LAST_ON_CHECK: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_parity)); // R7

    AST_CHECK_RUN: assert property (@(posedge clk) disable iff (rst)
        (out_parity && !out_last) |=> (out_valid && out_parity)); // R5

    AST_CLOSED_IN_CHECK: assert property (@(posedge clk) disable iff (rst)
        (out_parity && !out_last) |-> !in_ready); // R6

    AST_REOPEN_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        out_last |-> in_ready); // R6

    AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_parity); // R7

    AST_PARITY_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_parity |-> out_valid); // R5
endmodule

bind rs_stream_encoder rs_stream_encoder_sva #(.W(SYM_W)) sva_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_parity (out_parity),
    .out_last   (out_last)
);

// File: tb/rs_stream_encoder_tb_top.sv
module rs_stream_encoder_tb_top;
    localparam int W = 8, N = 204, P = 16, K = N - P, POLY = 285, ROOT0 = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         in_valid = 1'b0, in_sop = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready, out_valid, out_parity, out_last;
    logic [W-1:0] out_data;

    rs_stream_encoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_parity(out_parity), .out_last(out_last)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    string scen = "R10";

    int exp_t [0:511];
    int log_t [0:255];
    int gpoly [0:P];
    int pq[$];
    int coll[$];
    int cnt = 0;
    int seed = 7;
    bit e_valid = 0, e_par = 0, e_last = 0;
    int e_data = 0;

    function automatic int bmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[log_t[a] + log_t[b]];
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >> 16) & 255;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scen, what, act, expv);
        end
    endtask

    task automatic syndrome_check();
        int cw[$];
        int s, rt;
        cw = coll[coll.size()-N : coll.size()-1];
        for (int i = 0; i < P; i++) begin
            rt = exp_t[(ROOT0 + i) % 255];
            s = 0;
            foreach (cw[j]) s = bmul(s, rt) ^ cw[j];
            check(s == 0, "R4", "syndrome", s, 0);
        end
        coll.delete();
    endtask

    task automatic make_parity(int msg[$]);
        int rem [0:P-1];
        int fb;
        for (int j = 0; j < P; j++) rem[j] = 0;
        foreach (msg[m]) begin
            fb = msg[m] ^ rem[0];
            for (int j = 0; j < P - 1; j++) rem[j] = rem[j+1] ^ bmul(fb, gpoly[P-1-j]);
            rem[P-1] = bmul(fb, gpoly[0]);
        end
        for (int j = 0; j < P; j++) pq.push_back(rem[j]);
    endtask

    int msg_q[$];

    task automatic step(bit v, bit s, int d);
        string tag;
        @(negedge clk);
        tag = e_par ? "R5" : (e_valid ? "R2" : "R8");
        check(out_valid == e_valid, tag, "out_valid", out_valid, e_valid);
        if (e_valid) begin
            check(out_data == e_data[W-1:0], tag, "out_data", out_data, e_data);
            check(out_parity == e_par, tag, "out_parity", out_parity, e_par);
        end
        check(out_last == e_last, "R7", "out_last", out_last, e_last);
        check(in_ready == (pq.size() == 0), "R6", "in_ready", in_ready, pq.size() == 0);
        if (out_valid) coll.push_back(out_data);
        if (out_valid && out_last) syndrome_check();
        in_valid = v; in_sop = s; in_data = d[W-1:0];
        if (pq.size() > 0) begin
            e_valid = 1; e_par = 1; e_data = pq.pop_front(); e_last = (pq.size() == 0);
        end else if (v && (s || cnt > 0)) begin
            if (s) begin msg_q.delete(); cnt = 0; end
            msg_q.push_back(d); cnt++;
            e_valid = 1; e_par = 0; e_last = 0; e_data = d;
            if (cnt == K) begin make_parity(msg_q); cnt = 0; end
        end else begin
            e_valid = 0; e_par = 0; e_last = 0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    initial begin
        #(8 * 30000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int x;
        x = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = x; exp_t[i + 255] = x; log_t[x] = i;
            x = x << 1;
            if ((x & 256) != 0) x = x ^ POLY;
        end
        exp_t[510] = exp_t[0]; exp_t[511] = exp_t[1]; log_t[0] = 0;
        for (int k = 0; k <= P; k++) gpoly[k] = 0;
        gpoly[0] = 1;
        for (int i = 0; i < P; i++) begin
            for (int k = i + 1; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ bmul(gpoly[k], exp_t[(ROOT0 + i) % 255]);
            gpoly[0] = bmul(gpoly[0], exp_t[(ROOT0 + i) % 255]);
        end

        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_parity == 0 && out_last == 0, "R1", "outputs in reset", out_valid, 0);
        check(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && in_ready == 1, "R1", "after release", out_valid, 0);

        // R3: stray symbols without start flag
        scen = "R3";
        for (int i = 0; i < 3; i++) step(1, 0, 8'h55);
        idle(2);

        // R10: ramp block, offers during check window, then a random block back to back
        scen = "R10";
        for (int i = 0; i < K; i++) step(1, i == 0, i);
        for (int i = 0; i < P; i++) step(1, 0, 8'hAA);
        for (int i = 0; i < K; i++) step(1, i == 0, rnd());
        for (int i = 0; i < P; i++) step(0, 0, 0);

        // R8: gaps inside the block
        scen = "R8";
        for (int i = 0; i < K; i++) begin
            if (i % 3 == 2) step(0, 0, 8'h3C);
            step(1, i == 0, rnd());
        end
        idle(P + 3);

        // R9: fragment abandoned by a fresh start flag
        scen = "R9";
        for (int i = 0; i < 50; i++) step(1, i == 0, rnd());
        for (int i = 0; i < K; i++) step(1, i == 0, rnd());
        idle(P + 2);

        // R4: constant blocks
        scen = "R4";
        for (int i = 0; i < K; i++) step(1, i == 0, 0);
        for (int i = 0; i < P; i++) step(0, 0, 0);
        for (int i = 0; i < K; i++) step(1, i == 0, 255);
        idle(P + 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule